// File: doc/BRIEF.md
# DMA Control-Port Command Decoder

This block sits behind the byte-wide control port of a two-port byte DMA controller. Software programs the controller by writing a stream of bytes to that port. A byte written while nothing is pending is a base command. The decoder sorts it into one of seven write-register groups (G0 to G6) and stores it as that group's base register. From selected bits of the same byte, it builds an ordered list of the parameter bytes that must come next.

Each later byte lands in the parameter register at the head of that list until the list is used up. After that, the stream returns to base-command decoding. One parameter, the interrupt-control byte, replaces whatever remains of the list with a new list that its own bits select. G6 bytes are immediate commands: load the working addresses and count, enable, disable, reset, or queue a read-mask byte. Unrecognised codes raise a sticky error flag.

Addresses and the block length are presented already assembled as high byte times 256 plus low byte. The transfer engine captures them on the load strobe.

Top module: `dma_cmd_decoder`

## Requirements
- R1: After rst_n is asserted low, the following are all zero: every base and parameter register, dma_en, cmd_err, load_stb and reset_stb. The follow list is also empty.
- R2: A base byte d is classified in this order, and the first match wins:
  - (d&0x87)==0x00 is G2.
  - (d&0x87)==0x04 is G1.
  - Any other byte with bit 7 clear is G0.
  - (d&0x83)==0x80 is G3.
  - (d&0x83)==0x81 is G4.
  - (d&0xC7)==0x82 is G5.
  - (d&0x83)==0x83 is G6.
  
  The byte is stored in base_regs[8g+7:8g] for its group g.
- R3: For a G0 base byte, bits 3, 4, 5 and 6 each queue one follow byte, in this order: port A address low, port A address high, length low, length high.
- R4: For a G1 base byte, bit 6 queues the port A timing byte. For a G2 base byte, bit 6 queues the port B timing byte.
- R5: A G3 base byte always queues the mask byte. It then queues the match byte only if bit 4 is set.
- R6: For a G4 base byte, bits 2, 3 and 4 queue, in this order: port B address low, port B address high, interrupt control.
- R7: When the interrupt-control byte is received, the rest of the list is dropped. A new list is built with the pulse byte if that byte's bit 3 is set, then the vector byte if its bit 4 is set.
- R8: G6 code 0xCF pulses load_stb high for exactly the cycle after the write. a_addr, b_addr and blk_len are each {high,low}.
- R9: G6 code 0x87 sets dma_en and 0x83 clears it. A byte consumed as a parameter never changes dma_en.
- R10: G6 code 0xBB queues one read-mask follow byte.
- R11: cmd_err is set for a G6 code other than 0xCF, 0x87, 0x83, 0xC3 and 0xBB, and for a base byte that matches no group. It stays set until rst_n.
- R12: The follow list holds at most QDEPTH entries. After its last byte is consumed, the next byte is decoded as a base byte.
- R13: G6 code 0xC3 pulses reset_stb high for exactly the cycle after the write.
- R14: A cycle with wr_en low changes no output other than the strobes, which return low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control-port byte write strobe |
| wr_data | input | 8 | Control-port byte |
| base_regs | output | 56 | Base register of group g at bits 8g+7:8g |
| a_addr | output | 16 | Port A start address |
| b_addr | output | 16 | Port B start address |
| blk_len | output | 16 | Block length |
| a_timing | output | 8 | Port A timing byte |
| b_timing | output | 8 | Port B timing byte |
| mask_byte | output | 8 | Search mask byte |
| match_byte | output | 8 | Search match byte |
| irq_ctrl | output | 8 | Interrupt control byte |
| pulse_ctrl | output | 8 | Pulse control byte |
| irq_vector | output | 8 | Interrupt vector byte |
| rd_mask | output | 8 | Read mask byte |
| load_stb | output | 1 | One-cycle load of working addresses and count |
| reset_stb | output | 1 | One-cycle reset command pulse |
| dma_en | output | 1 | DMA enable flag |
| cmd_err | output | 1 | Sticky unknown/unsupported command flag |

## Verification
Several properties are checked on every cycle:
- cmd_err stays set once raised.
- dma_en holds whenever no base byte is written.
- The follow list never exceeds its depth, and its cursor stays inside it.
- Consuming the last queued byte empties the list.
- The strobes only follow a write.

Only the bench scenarios can show the following:
- Each follow byte reaches the right register, in the right order, for every group.
- The interrupt-control byte rewrites the list.
- A parameter byte that looks like a command has no command effect.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
   // parameter register identifiers, used as follow-list entries
   typedef enum logic [3:0] {
      P_A_LO, P_A_HI, P_LEN_LO, P_LEN_HI,
      P_A_TIM, P_B_TIM, P_MASK, P_MATCH,
      P_B_LO, P_B_HI, P_INTC, P_PULSE,
      P_VEC, P_RDMASK
   } preg_e;
   localparam int NUM_PREG = 14;

   // write-register groups; G_BAD marks a byte that fits none
   typedef enum logic [2:0] {
      G0, G1, G2, G3, G4, G5, G6, G_BAD
   } grp_e;
   localparam int NUM_GRP = 7;

   // immediate command codes in group 6
   localparam logic [7:0] CMD_LOAD    = 8'hCF;
   localparam logic [7:0] CMD_ENABLE  = 8'h87;
   localparam logic [7:0] CMD_DISABLE = 8'h83;
   localparam logic [7:0] CMD_RESET   = 8'hC3;
   localparam logic [7:0] CMD_RDMASK  = 8'hBB;
endpackage

// File: rtl/cbd_classify.sv
module cbd_classify
   import cbd_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic [DW-1:0] d,
   output grp_e          grp
);
   if (DW != 8) begin : g_bad_dw
      $error("cbd_classify: command codes are byte wide");
   end

   // first match wins; the order is part of the decode
   always_comb begin
      if ((d & 8'h87) == 8'h00)      grp = G2;
      else if ((d & 8'h87) == 8'h04) grp = G1;
      else if (!d[7])                grp = G0;
      else if ((d & 8'h83) == 8'h80) grp = G3;
      else if ((d & 8'h83) == 8'h81) grp = G4;
      else if ((d & 8'hC7) == 8'h82) grp = G5;
      else if ((d & 8'h83) == 8'h83) grp = G6;
      else                           grp = G_BAD;
   end
endmodule

// File: rtl/cbd_plan.sv
module cbd_plan
   import cbd_pkg::*;
#(
   parameter int DW     = 8,
   parameter int QDEPTH = 4,
   localparam int CW    = $clog2(QDEPTH + 1),
   localparam int IW    = (QDEPTH > 1) ? $clog2(QDEPTH) : 1
) (
   input  logic [DW-1:0] d,
   input  grp_e          grp,
   input  logic          rebuild,
   output preg_e         list [QDEPTH],
   output logic [CW-1:0] cnt,
   output logic          do_load,
   output logic          do_en,
   output logic          do_dis,
   output logic          do_rst,
   output logic          bad
);
   localparam int NCAND = 4;

   if (QDEPTH < NCAND) begin : g_bad_depth
      $error("cbd_plan: QDEPTH must hold the longest follow list");
   end

   preg_e cand_id [NCAND];
   logic [NCAND-1:0] cand_v;

   // candidate slots in their fixed order, then compacted
   always_comb begin
      cand_v  = '0;
      for (int k = 0; k < NCAND; k++) cand_id[k] = P_A_LO;
      do_load = 1'b0;
      do_en   = 1'b0;
      do_dis  = 1'b0;
      do_rst  = 1'b0;
      bad     = 1'b0;
      if (rebuild) begin
         cand_v[0] = d[3]; cand_id[0] = P_PULSE;
         cand_v[1] = d[4]; cand_id[1] = P_VEC;
      end else begin
         case (grp)
            G0: begin
               cand_v[0] = d[3]; cand_id[0] = P_A_LO;
               cand_v[1] = d[4]; cand_id[1] = P_A_HI;
               cand_v[2] = d[5]; cand_id[2] = P_LEN_LO;
               cand_v[3] = d[6]; cand_id[3] = P_LEN_HI;
            end
            G1: begin
               cand_v[0] = d[6]; cand_id[0] = P_A_TIM;
            end
            G2: begin
               cand_v[0] = d[6]; cand_id[0] = P_B_TIM;
            end
            G3: begin
               cand_v[0] = 1'b1; cand_id[0] = P_MASK;
               cand_v[1] = d[4]; cand_id[1] = P_MATCH;
            end
            G4: begin
               cand_v[0] = d[2]; cand_id[0] = P_B_LO;
               cand_v[1] = d[3]; cand_id[1] = P_B_HI;
               cand_v[2] = d[4]; cand_id[2] = P_INTC;
            end
            G5: ;
            G6: begin
               case (d)
                  CMD_LOAD:    do_load = 1'b1;
                  CMD_ENABLE:  do_en   = 1'b1;
                  CMD_DISABLE: do_dis  = 1'b1;
                  CMD_RESET:   do_rst  = 1'b1;
                  CMD_RDMASK: begin
                     cand_v[0] = 1'b1; cand_id[0] = P_RDMASK;
                  end
                  default:     bad     = 1'b1;
               endcase
            end
            default: bad = 1'b1;
         endcase
      end
   end

   always_comb begin
      cnt = '0;
      for (int q = 0; q < QDEPTH; q++) list[q] = P_A_LO;
      for (int k = 0; k < NCAND; k++) begin
         if (cand_v[k]) begin
            list[cnt[IW-1:0]] = cand_id[k];
            cnt = cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/cbd_follow_queue.sv
module cbd_follow_queue
   import cbd_pkg::*;
#(
   parameter int QDEPTH = 4,
   localparam int CW    = $clog2(QDEPTH + 1),
   localparam int IW    = (QDEPTH > 1) ? $clog2(QDEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  preg_e         load_list [QDEPTH],
   input  logic [CW-1:0] load_cnt,
   input  logic          advance,
   output logic          pending,
   output preg_e         head
);
   preg_e         q [QDEPTH];
   logic [CW-1:0] num;
   logic [CW-1:0] cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         num <= '0;
         cur <= '0;
         for (int i = 0; i < QDEPTH; i++) q[i] <= P_A_LO;
      end else if (load) begin
         num <= load_cnt;
         cur <= '0;
         for (int i = 0; i < QDEPTH; i++) q[i] <= load_list[i];
      end else if (advance) begin
         if (cur + 1'b1 >= num) begin
            num <= '0;
            cur <= '0;
         end else begin
            cur <= cur + 1'b1;
         end
      end
   end

   assign pending = (num != '0);
   assign head    = q[cur[IW-1:0]];

   // list bounded by its storage, cursor inside the list (R12)
   assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (num <= CW'(QDEPTH)) && (!pending || cur < num));

   // consuming the final entry empties the list (R12)
   assert_drain_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load && pending && (cur + 1'b1 >= num)) |=> !pending);
endmodule

// File: rtl/dma_cmd_decoder.sv
module dma_cmd_decoder
   import cbd_pkg::*;
#(
   parameter int DW     = 8,
   parameter int QDEPTH = 4,
   localparam int AW    = 2 * DW,
   localparam int CW    = $clog2(QDEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [DW-1:0]       wr_data,
   output logic [NUM_GRP*DW-1:0] base_regs,
   output logic [AW-1:0]       a_addr,
   output logic [AW-1:0]       b_addr,
   output logic [AW-1:0]       blk_len,
   output logic [DW-1:0]       a_timing,
   output logic [DW-1:0]       b_timing,
   output logic [DW-1:0]       mask_byte,
   output logic [DW-1:0]       match_byte,
   output logic [DW-1:0]       irq_ctrl,
   output logic [DW-1:0]       pulse_ctrl,
   output logic [DW-1:0]       irq_vector,
   output logic [DW-1:0]       rd_mask,
   output logic                load_stb,
   output logic                reset_stb,
   output logic                dma_en,
   output logic                cmd_err
);
   if (DW != 8) begin : g_bad_dw
      $error("dma_cmd_decoder: control port is byte wide");
   end

   grp_e          grp;
   preg_e         plan_list [QDEPTH];
   logic [CW-1:0] plan_cnt;
   logic          do_load, do_en, do_dis, do_rst, bad;
   logic          pending;
   preg_e         head;
   logic          base_wr, param_wr, intc_wr, q_load;
   logic [DW-1:0] preg [NUM_PREG];

   cbd_classify #(.DW(DW)) u_classify (
      .d   (wr_data),
      .grp (grp)
   );

   cbd_plan #(.DW(DW), .QDEPTH(QDEPTH)) u_plan (
      .d       (wr_data),
      .grp     (grp),
      .rebuild (pending),
      .list    (plan_list),
      .cnt     (plan_cnt),
      .do_load (do_load),
      .do_en   (do_en),
      .do_dis  (do_dis),
      .do_rst  (do_rst),
      .bad     (bad)
   );

   assign base_wr  = wr_en && !pending;
   assign param_wr = wr_en && pending;
   assign intc_wr  = param_wr && (head == P_INTC);
   assign q_load   = (base_wr && (grp != G_BAD)) || intc_wr;

   cbd_follow_queue #(.QDEPTH(QDEPTH)) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (q_load),
      .load_list (plan_list),
      .load_cnt  (plan_cnt),
      .advance   (param_wr),
      .pending   (pending),
      .head      (head)
   );

   // parameter registers, one per follow-list identifier
   for (genvar i = 0; i < NUM_PREG; i++) begin : g_preg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 preg[i] <= '0;
         else if (param_wr && (head == preg_e'(i)))  preg[i] <= wr_data;
      end
   end

   // base register per group
   for (genvar g = 0; g < NUM_GRP; g++) begin : g_base
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              base_regs[g*DW +: DW] <= '0;
         else if (base_wr && (grp == grp_e'(g)))  base_regs[g*DW +: DW] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dma_en    <= 1'b0;
         cmd_err   <= 1'b0;
         load_stb  <= 1'b0;
         reset_stb <= 1'b0;
      end else begin
         load_stb  <= base_wr && do_load;
         reset_stb <= base_wr && do_rst;
         if (base_wr && do_en)       dma_en <= 1'b1;
         else if (base_wr && do_dis) dma_en <= 1'b0;
         if (base_wr && bad)         cmd_err <= 1'b1;
      end
   end

   assign a_addr     = {preg[P_A_HI],   preg[P_A_LO]};
   assign b_addr     = {preg[P_B_HI],   preg[P_B_LO]};
   assign blk_len    = {preg[P_LEN_HI], preg[P_LEN_LO]};
   assign a_timing   = preg[P_A_TIM];
   assign b_timing   = preg[P_B_TIM];
   assign mask_byte  = preg[P_MASK];
   assign match_byte = preg[P_MATCH];
   assign irq_ctrl   = preg[P_INTC];
   assign pulse_ctrl = preg[P_PULSE];
   assign irq_vector = preg[P_VEC];
   assign rd_mask    = preg[P_RDMASK];

   // error flag is sticky (R11)
   assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |=> cmd_err);

   // enable moves only on a base write (R9)
   assert_en_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || pending) |=> $stable(dma_en));

   // strobes only follow a write (R8, R13)
   assert_load_after_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb |-> $past(wr_en));
   assert_reset_after_wr_R13: assert property (@(posedge clk) disable iff (!rst_n)
      reset_stb |-> $past(wr_en));

   // an idle cycle leaves the assembled parameters alone (R14)
   assert_idle_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(a_addr) && $stable(b_addr) && $stable(blk_len)
                  && $stable(base_regs)));
endmodule

// File: tb/dma_cmd_decoder_tb.sv
module dma_cmd_decoder_tb;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n, wr_en;
   logic [7:0]  wr_data;
   logic [55:0] base_regs;
   logic [15:0] a_addr, b_addr, blk_len;
   logic [7:0]  a_timing, b_timing, mask_byte, match_byte;
   logic [7:0]  irq_ctrl, pulse_ctrl, irq_vector, rd_mask;
   logic        load_stb, reset_stb, dma_en, cmd_err;

   dma_cmd_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .base_regs(base_regs), .a_addr(a_addr), .b_addr(b_addr), .blk_len(blk_len),
      .a_timing(a_timing), .b_timing(b_timing), .mask_byte(mask_byte),
      .match_byte(match_byte), .irq_ctrl(irq_ctrl), .pulse_ctrl(pulse_ctrl),
      .irq_vector(irq_vector), .rd_mask(rd_mask), .load_stb(load_stb),
      .reset_stb(reset_stb), .dma_en(dma_en), .cmd_err(cmd_err)
   );

   // parameter slot numbers used by the model
   localparam int S_ALO = 0, S_AHI = 1, S_LLO = 2, S_LHI = 3, S_ATIM = 4,
                  S_BTIM = 5, S_MASK = 6, S_MATCH = 7, S_BLO = 8, S_BHI = 9,
                  S_INTC = 10, S_PULSE = 11, S_VEC = 12, S_RDM = 13;

   int n_vec = 0;
   int n_bad = 0;

   logic [7:0] m_base [7];
   logic [7:0] m_par  [14];
   int         m_q    [4];
   int         m_num, m_cur;
   bit         m_en, m_err, m_ld, m_rs;

   function automatic int f_grp(input logic [7:0] d);
      if ((d & 8'h87) == 8'h00)      return 2;
      else if ((d & 8'h87) == 8'h04) return 1;
      else if (!d[7])                return 0;
      else if ((d & 8'h83) == 8'h80) return 3;
      else if ((d & 8'h83) == 8'h81) return 4;
      else if ((d & 8'hC7) == 8'h82) return 5;
      else if ((d & 8'h83) == 8'h83) return 6;
      return 7;
   endfunction

   task automatic push(input int id);
      m_q[m_num] = id;
      m_num++;
   endtask

   task automatic model_reset();
      for (int i = 0; i < 7; i++)  m_base[i] = 8'h00;
      for (int i = 0; i < 14; i++) m_par[i]  = 8'h00;
      m_num = 0; m_cur = 0; m_en = 0; m_err = 0; m_ld = 0; m_rs = 0;
   endtask

   task automatic model_write(input logic [7:0] d);
      int g, idx;
      m_ld = 0; m_rs = 0;
      if (m_num == 0) begin
         g = f_grp(d);
         if (g == 7) m_err = 1;
         else begin
            m_base[g] = d; m_cur = 0;
            case (g)
               0: begin
                  if (d[3]) push(S_ALO); if (d[4]) push(S_AHI);
                  if (d[5]) push(S_LLO); if (d[6]) push(S_LHI);
               end
               1: if (d[6]) push(S_ATIM);
               2: if (d[6]) push(S_BTIM);
               3: begin push(S_MASK); if (d[4]) push(S_MATCH); end
               4: begin
                  if (d[2]) push(S_BLO); if (d[3]) push(S_BHI);
                  if (d[4]) push(S_INTC);
               end
               6: case (d)
                  8'hCF: m_ld = 1;
                  8'h87: m_en = 1;
                  8'h83: m_en = 0;
                  8'hC3: m_rs = 1;
                  8'hBB: push(S_RDM);
                  default: m_err = 1;
               endcase
               default: ;
            endcase
         end
      end else begin
         idx = m_q[m_cur];
         m_par[idx] = d;
         m_cur++;
         if (m_cur >= m_num) begin m_num = 0; m_cur = 0; end
         if (idx == S_INTC) begin
            m_num = 0; m_cur = 0;
            if (d[3]) push(S_PULSE);
            if (d[4]) push(S_VEC);
         end
      end
   endtask

   task automatic chk(input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      for (int g = 0; g < 7; g++) chk(req, "base", 16'(base_regs[g*8 +: 8]), 16'(m_base[g]));
      chk(req, "a_addr",  a_addr,  {m_par[S_AHI], m_par[S_ALO]});
      chk(req, "b_addr",  b_addr,  {m_par[S_BHI], m_par[S_BLO]});
      chk(req, "blk_len", blk_len, {m_par[S_LHI], m_par[S_LLO]});
      chk(req, "a_timing",   16'(a_timing),   16'(m_par[S_ATIM]));
      chk(req, "b_timing",   16'(b_timing),   16'(m_par[S_BTIM]));
      chk(req, "mask_byte",  16'(mask_byte),  16'(m_par[S_MASK]));
      chk(req, "match_byte", 16'(match_byte), 16'(m_par[S_MATCH]));
      chk(req, "irq_ctrl",   16'(irq_ctrl),   16'(m_par[S_INTC]));
      chk(req, "pulse_ctrl", 16'(pulse_ctrl), 16'(m_par[S_PULSE]));
      chk(req, "irq_vector", 16'(irq_vector), 16'(m_par[S_VEC]));
      chk(req, "rd_mask",    16'(rd_mask),    16'(m_par[S_RDM]));
      chk(req, "load_stb",   16'(load_stb),   16'(m_ld));
      chk(req, "reset_stb",  16'(reset_stb),  16'(m_rs));
      chk(req, "dma_en",     16'(dma_en),     16'(m_en));
      chk(req, "cmd_err",    16'(cmd_err),    16'(m_err));
   endtask

   task automatic put(input logic [7:0] d, input string req);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      model_write(d);
      @(negedge clk);
      wr_en = 1'b0;
      check_all(req);
   endtask

   task automatic idle(input logic [7:0] d, input string req);
      @(negedge clk);
      wr_en = 1'b0; wr_data = d;
      m_ld = 0; m_rs = 0;
      @(negedge clk);
      check_all(req);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
      model_reset();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] pick [12];
      logic [7:0] b;
      rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
      void'($urandom(32'h5EED_0042));
      do_reset();

      // R2 R3: full G0 list, then partial list
      put(8'h79, "R2"); put(8'h34, "R3"); put(8'h12, "R3");
      put(8'h05, "R3"); put(8'h00, "R3");
      put(8'h29, "R3"); put(8'hAA, "R3"); put(8'h07, "R3");
      // R4
      put(8'h44, "R4"); put(8'h3C, "R4");
      put(8'h40, "R4"); put(8'hC5, "R4");
      put(8'h00, "R4");
      // R5
      put(8'h80, "R5"); put(8'hF0, "R5");
      put(8'h90, "R5"); put(8'h0F, "R5"); put(8'h55, "R5");
      // R6 R7: B address, interrupt control rebuilds list
      put(8'h9D, "R6"); put(8'h78, "R6"); put(8'h56, "R6");
      put(8'h18, "R7"); put(8'h21, "R7"); put(8'h42, "R7");
      put(8'h91, "R6"); put(8'h00, "R7");
      put(8'h82, "R2");
      // R8 R9 R13
      put(8'hCF, "R8"); idle(8'hCF, "R14");
      put(8'h87, "R9"); put(8'h09, "R9"); put(8'h83, "R9");
      put(8'h83, "R9"); put(8'h09, "R12"); put(8'h87, "R12");
      put(8'hC3, "R13"); idle(8'h87, "R14");
      // R10
      put(8'hBB, "R10"); put(8'h5A, "R10");
      // R11
      put(8'hC2, "R11"); put(8'h87, "R11"); put(8'hA7, "R11");

      do_reset();
      put(8'hA7, "R11"); put(8'h86, "R11");

      do_reset();
      pick = '{8'h79, 8'h29, 8'h44, 8'h40, 8'h90, 8'h80, 8'h9D, 8'hCF,
               8'h87, 8'h83, 8'hBB, 8'hC3};
      for (int n = 0; n < 600; n++) begin
         if (($urandom % 4) != 0) b = pick[$urandom % 12];
         else                     b = 8'($urandom);
         if (($urandom % 8) == 0) idle(b, "R14");
         else                     put(b, "R12");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule